// File: doc/BRIEF.md
# Two-Modulus Prescaler Swallow Counter

This block steers an external prescaler that divides by either P or P+1. Each rising edge of its clock is one output pulse of that prescaler. Within a count cycle of M pulses, the block holds the modulus-control line low for the first A pulses and high for the rest. The prescaler therefore divides by P+1 for A pulses and by P for M-A pulses. One full cycle spans M·P + A input periods of the prescaler.

On the last pulse of each cycle the block raises a one-pulse strobe that feeds the phase detector. It then starts the next cycle with the A and M values present on its pending inputs. A resynchronise input restarts the cycle at once with the pending values. A configuration-fault output reports loaded values that break the divider's rules, but counting still continues with those values.

Top module: `swallow_ctr`

## Requirements
- R1: While reset is asserted, `modCtl`, `vcoStrobe` and `cfgFault` are low. The first rising edge after reset loads `pendA` and `pendM` and makes that pulse position 0 of a new cycle.
- R2: Pulse positions are counted 0 to M-1 within a cycle. `modCtl` is low at positions below A and high from position A to the end of the cycle.
- R3: With a loaded A of 0, `modCtl` is already high at position 0.
- R4: A cycle lasts exactly M pulses. `vcoStrobe` is high only at position M-1, for one pulse.
- R5: If the prescaler divides by P+1 while `modCtl` is low and by P while it is high, one cycle totals M·P + min(A, M) prescaler input periods. That equals M·P + A whenever M > A.
- R6: Values on `pendA` and `pendM` are taken only at the edge that follows position M-1. A change in mid-cycle leaves the running cycle unchanged.
- R7: A rising edge with `resync` high loads the pending values and makes that pulse position 0, wherever the cycle stood.
- R8: `cfgFault` is high while the loaded M is below 8 or not greater than the loaded A. The counters still use the loaded values. When A ≥ M, `modCtl` stays low for the whole cycle.
- R9: A loaded M of 0 gives a cycle of 1024 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output; each rising edge is one counted pulse |
| rstN | input | 1 | Asynchronous reset, active low |
| resync | input | 1 | Restart the cycle with pending values at this edge |
| pendA | input | 7 | Pending swallow count A (0..127) |
| pendM | input | 10 | Pending main count M (8..1023 valid) |
| modCtl | output | 1 | Modulus control: low selects P+1, high selects P |
| vcoStrobe | output | 1 | One-pulse divided-VCO strobe at the last pulse of a cycle |
| cfgFault | output | 1 | Loaded M below 8 or not above loaded A |

## Verification
All three outputs come from registers alone. Every result is therefore due on the output one rising edge after the stimulus that causes it: a load, a resync, or the step after position M-1. The bench drives inputs and samples outputs on falling edges, so each value is read half a period after the edge that set it. A behavioural model tracks pulse position, A and M with integers and is compared on every falling edge. A second tally adds up prescaler periods between strobes to confirm the total division ratio.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // take pending A/M and restart at position 0
    logic step;   // advance one pulse position
    logic idle;   // no cycle loaded yet since reset
  } swCtl_t;
endpackage

// File: rtl/swallow_ctl.sv
module swallow_ctl
  import swallow_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   resync,
  input  logic   mTerm,
  output swCtl_t ctl
);
  logic startPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startPend <= 1'b1;
    else       startPend <= 1'b0;
  end

  always_comb begin
    ctl.idle = startPend;
    ctl.load = startPend | resync | mTerm;
    ctl.step = ~ctl.load;
  end
endmodule

// File: rtl/swallow_dp.sv
module swallow_dp
  import swallow_pkg::*;
#(
  parameter int A_W   = 7,
  parameter int M_W   = 10,
  parameter int M_MIN = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  swCtl_t         ctl,
  input  logic [A_W-1:0] pendA,
  input  logic [M_W-1:0] pendM,
  output logic           mTerm,
  output logic           modCtl,
  output logic           vcoStrobe,
  output logic           cfgFault
);
  localparam logic [M_W-1:0] M_ONE = M_W'(1);
  localparam logic [M_W-1:0] M_LIM = M_W'(M_MIN);

  logic [A_W-1:0] aCnt, curA;
  logic [M_W-1:0] mCnt, curM;
  logic [M_W-1:0] curAExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aCnt <= '0;
      mCnt <= '0;
      curA <= '0;
      curM <= '0;
    end else if (ctl.load) begin
      aCnt <= pendA;
      mCnt <= pendM - M_ONE;   // M of 0 wraps to a full-range cycle
      curA <= pendA;
      curM <= pendM;
    end else if (ctl.step) begin
      mCnt <= mCnt - M_ONE;
      if (aCnt != '0) aCnt <= aCnt - A_W'(1);
    end
  end

  generate
    if (M_W >= A_W) begin : g_ext
      assign curAExt = M_W'(curA);
    end else begin : g_trunc
      assign curAExt = curA[M_W-1:0];
    end
  endgenerate

  assign mTerm     = (mCnt == '0);
  assign modCtl    = ~ctl.idle & (aCnt == '0);
  assign vcoStrobe = ~ctl.idle & mTerm;
  assign cfgFault  = ~ctl.idle & ((curM < M_LIM) | (curM <= curAExt));
endmodule

// File: rtl/swallow_ctr.sv
module swallow_ctr
  import swallow_pkg::*;
#(
  parameter int A_W   = 7,
  parameter int M_W   = 10,
  parameter int M_MIN = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           resync,
  input  logic [A_W-1:0] pendA,
  input  logic [M_W-1:0] pendM,
  output logic           modCtl,
  output logic           vcoStrobe,
  output logic           cfgFault
);
  swCtl_t ctl;
  logic   mTerm;

  swallow_ctl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .resync (resync),
    .mTerm  (mTerm),
    .ctl    (ctl)
  );

  swallow_dp #(.A_W(A_W), .M_W(M_W), .M_MIN(M_MIN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .pendA     (pendA),
    .pendM     (pendM),
    .mTerm     (mTerm),
    .modCtl    (modCtl),
    .vcoStrobe (vcoStrobe),
    .cfgFault  (cfgFault)
  );
endmodule

// File: rtl/swallow_ctr_chk.sv
module swallow_ctr_chk #(
  parameter int A_W   = 7,
  parameter int M_W   = 10,
  parameter int M_MIN = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           resync,
  input logic [A_W-1:0] pendA,
  input logic [M_W-1:0] pendM,
  input logic           modCtl,
  input logic           vcoStrobe,
  input logic           cfgFault
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!modCtl && !vcoStrobe && !cfgFault));

  // R2
  mod_stays_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modCtl && !vcoStrobe && !resync) |=> modCtl);

  // R3
  restart_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vcoStrobe && !resync) |=> (modCtl == ($past(pendA) == '0)));

  // R7
  resync_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (modCtl == ($past(pendA) == '0)));

  // R8
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (cfgFault == (($past(pendM) < M_W'(M_MIN)) ||
                             ($past(pendM) <= M_W'($past(pendA))))));
endmodule

bind swallow_ctr swallow_ctr_chk #(.A_W(A_W), .M_W(M_W), .M_MIN(M_MIN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .resync    (resync),
  .pendA     (pendA),
  .pendM     (pendM),
  .modCtl    (modCtl),
  .vcoStrobe (vcoStrobe),
  .cfgFault  (cfgFault)
);

// File: tb/tb_swallow_ctr.sv
module tb_swallow_ctr;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       resync = 1'b0;
  logic [6:0] pendA = 7'd5;
  logic [9:0] pendM = 10'd12;
  logic       modCtl, vcoStrobe, cfgFault;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // reference model state
  int  mA = 0, mM = 0, mK = 0;
  bit  mIdle = 1'b1;
  int  acc = 0;

  swallow_ctr dut (
    .clk(clk), .rstN(rstN), .resync(resync),
    .pendA(pendA), .pendM(pendM),
    .modCtl(modCtl), .vcoStrobe(vcoStrobe), .cfgFault(cfgFault)
  );

  always #5 clk = ~clk;

  function automatic int effM(int m);
    return (m == 0) ? 1024 : m;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIdle = 1'b1; mK = 0;
    end else if (mIdle || resync || mK == effM(mM) - 1) begin
      mA = int'(pendA); mM = int'(pendM); mK = 0; mIdle = 1'b0;
    end else begin
      mK = mK + 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) k=%0d: actual %0d expected %0d", tag, phase, mK, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int eMod, eStr, eFlt, em;
    em   = effM(mM);
    eMod = (!mIdle && mK >= mA) ? 1 : 0;
    eStr = (!mIdle && mK == em - 1) ? 1 : 0;
    eFlt = (!mIdle && (mM < 8 || mM <= mA)) ? 1 : 0;
    if (!rstN) begin
      check("R1 modCtl", int'(modCtl), 0);
      check("R1 vcoStrobe", int'(vcoStrobe), 0);
      check("R1 cfgFault", int'(cfgFault), 0);
    end else begin
      check((mA == 0) ? "R3 modCtl" : "R2 modCtl", int'(modCtl), eMod);
      check((mM == 0) ? "R9 vcoStrobe" : "R4 vcoStrobe", int'(vcoStrobe), eStr);
      check("R8 cfgFault", int'(cfgFault), eFlt);
      if (!mIdle) begin
        if (mK == 0) acc = 0;
        acc += modCtl ? P : P + 1;
        if (eStr == 1)
          check("R5 ratio", acc, em * P + ((mA < em) ? mA : em));
      end
    end
  end

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doResync(int a, int m);
    @(negedge clk);
    pendA = 7'(a); pendM = 10'(m); resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
  endtask

  initial begin
    #1 rstN = 1'b0;
    waitN(3);
    phase = "R1";
    rstN = 1'b1;
    phase = "R2";
    waitN(40);                  // A=5, M=12
    phase = "R6";
    waitN(5);
    pendA = 7'd0; pendM = 10'd9; // change mid-cycle
    waitN(40);
    phase = "R3";
    waitN(20);
    phase = "R7";
    waitN(4);
    doResync(3, 20);
    waitN(7);
    doResync(17, 40);
    waitN(100);
    phase = "R8";
    doResync(10, 10);
    waitN(25);
    doResync(2, 5);
    waitN(15);
    doResync(20, 12);
    waitN(30);
    phase = "R9";
    doResync(1, 0);
    waitN(2100);
    phase = "R5";
    doResync(127, 1023);
    waitN(2100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog (%s): actual timeout expected completion", phase);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule